// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Command Transmitter

This block is the host end of a chain of serial DAC devices that share one shift clock and one latch strobe. The host's data line enters the first device, and each device's serial output feeds the next device's data input. On a start request the block takes one command per device, where a command is a 4-bit channel address and a 10-bit code. It builds a 14-bit word for each device and shifts the words out back to back, beginning with the word for the device farthest from the host. A single latch pulse then commits every device together.

The shift clock comes from the system clock. Each high phase and each low phase of the shift clock lasts `half_div` system cycles, and a value of 0 counts as 1. Data changes when the shift clock falls, so the receivers capture it on the rising edge with setup and hold margins that are about equal. The block can also send an active-low reset pulse to the devices. The FSM states are IDLE, RSTP (device reset pulse), LO (shift clock low), HI (shift clock high), GAP (low time before the latch), LOAD (latch high) and FIN (done pulse). The transitions are as follows:

- IDLE→RSTP when `rst_req` is high. This takes priority over start.
- IDLE→LO when `start` is high. The commands, the divider and the bit order are captured at this point.
- RSTP→IDLE, LO→HI, GAP→LOAD and LOAD→FIN each happen when the phase timer expires.
- HI→LO happens when the phase timer expires and bits are still left to send. HI→GAP happens when the phase timer expires and the last bit has been sent.
- FIN→IDLE happens unconditionally.

Top module: `serdac_chain_tx`

## Requirements
- R1: After reset, `sck`=0, `ld`=0, `sdo`=0, `busy`=0, `done`=0 and `dev_rst_n`=1.
- R2: Each device word is sent as 14 bits. The address goes first, from bit 0 up to bit 3, and the 10-bit code follows.
- R3: Command slice d (`cmd_addr[4d+:4]`, `cmd_code[10d+:10]`) goes to device d, where device 0 is nearest the host. The word for device N_DEV-1 is shifted first, so after the transfer each device holds its own word.
- R4: A transfer produces exactly N_DEV×14 rising edges of `sck`.
- R5: `sdo` changes only when `sck` falls, never while `sck` stays high.
- R6: Each high phase and each low phase of `sck` lasts exactly `half_div` system cycles, and `half_div`=0 acts as 1.
- R7: After the last falling edge of `sck`, `ld` stays low for `half_div` cycles and then goes high for `half_div` cycles. `ld` is never high while `sck` is high.
- R8: With `msb_first`=0 the code goes out from bit 0 up to bit 9. With `msb_first`=1 it goes out from bit 9 down to bit 0.
- R9: `start` is ignored while `busy`=1. Changing the command inputs during a transfer has no effect, and each start produces exactly one latch pulse.
- R10: `done` is high for exactly one cycle, in the first cycle after `ld` returns low.
- R11: When `rst_req` is high in idle, `dev_rst_n` goes low for `half_div` cycles. During that time `busy`=1 and `sck` and `ld` stay low.
- R12: When `rst_req` and `start` are both high in idle, only the reset pulse is issued and no bits are shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | Shift clock half period in system cycles |
| msb_first | input | 1 | Send the code field from bit 9 down to bit 0 |
| start | input | 1 | Begin a chain transfer |
| rst_req | input | 1 | Issue a device reset pulse |
| cmd_addr | input | N_DEV*4 | Channel address for each device |
| cmd_code | input | N_DEV*10 | 10-bit code for each device |
| sck | output | 1 | Shift clock to the chain |
| sdo | output | 1 | Serial data to the first device |
| ld | output | 1 | Shared latch strobe |
| dev_rst_n | output | 1 | Active-low reset to the devices |
| busy | output | 1 | Transfer or reset pulse in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the properties that hold at all times:

- `sdo` stays stable while `sck` is high.
- `ld` and `sck` are never high together.
- `ld` and the device reset only happen while `busy` is high.
- `done` only follows a cycle with `ld` high.
- The phase counter stays below its limit.

Only the bench scenarios can show the ordering of the frame and the division of work across the chain. For this the bench models the chain as one long shift register, decodes each device's word at the latch, and compares it with the commands that were issued. The same scenarios show the exact phase widths for each divider value, the effect of bit order, and that requests and command changes made during a transfer have no effect.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
    localparam int ADDR_W = 4;
    localparam int CODE_W = 10;
    localparam int WORD_W = ADDR_W + CODE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSTP,
        ST_LO,
        ST_HI,
        ST_GAP,
        ST_LOAD,
        ST_FIN
    } tx_state_e;
endpackage

// File: rtl/serdac_word_pack.sv
// Builds one device word; bit 0 of word is the first bit on the wire.
module serdac_word_pack
    import serdac_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] code,
    input  logic              msb_first,
    output logic [WORD_W-1:0] word
);
    assign word[ADDR_W-1:0] = addr;

    generate
        for (genvar i = 0; i < CODE_W; i++) begin : g_code_bit
            // R8: bit order of the code field
            assign word[ADDR_W+i] = msb_first ? code[CODE_W-1-i] : code[i];
        end
    endgenerate
endmodule

// File: rtl/serdac_phase_timer.sv
// Counts system cycles within one timed FSM phase.
module serdac_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_W'(limit - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: phase counter never passes its limit
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));
endmodule

// File: rtl/serdac_chain_tx.sv
module serdac_chain_tx
    import serdac_pkg::*;
#(
    parameter int N_DEV = 3,
    parameter int DIV_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIV_W-1:0]         half_div,
    input  logic                     msb_first,
    input  logic                     start,
    input  logic                     rst_req,
    input  logic [N_DEV*ADDR_W-1:0]  cmd_addr,
    input  logic [N_DEV*CODE_W-1:0]  cmd_code,
    output logic                     sck,
    output logic                     sdo,
    output logic                     ld,
    output logic                     dev_rst_n,
    output logic                     busy,
    output logic                     done
);
    localparam int TOTAL = N_DEV * WORD_W;
    localparam int BC_W  = $clog2(TOTAL);

    tx_state_e         state, nstate;
    logic [TOTAL-1:0]  frame;
    logic [TOTAL-1:0]  sr;
    logic [BC_W-1:0]   bits_left;
    logic [DIV_W-1:0]  hreg;
    logic              tick;
    logic              run;
    logic              accept;
    logic              rst_go;

    // R3: farthest device's word occupies the first-sent bits
    generate
        for (genvar d = 0; d < N_DEV; d++) begin : g_dev
            serdac_word_pack u_pack (
                .addr      (cmd_addr[d*ADDR_W +: ADDR_W]),
                .code      (cmd_code[d*CODE_W +: CODE_W]),
                .msb_first (msb_first),
                .word      (frame[(N_DEV-1-d)*WORD_W +: WORD_W])
            );
        end
    endgenerate

    assign run    = (state != ST_IDLE) && (state != ST_FIN);
    assign rst_go = (state == ST_IDLE) && rst_req;
    assign accept = (state == ST_IDLE) && !rst_req && start;

    serdac_phase_timer #(.CNT_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (hreg),
        .tick  (tick)
    );

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (rst_req)    nstate = ST_RSTP;
                else if (start) nstate = ST_LO;
            end
            ST_RSTP: if (tick) nstate = ST_IDLE;
            ST_LO:   if (tick) nstate = ST_HI;
            ST_HI: begin
                if (tick) nstate = (bits_left == '0) ? ST_GAP : ST_LO;
            end
            ST_GAP:  if (tick) nstate = ST_LOAD;
            ST_LOAD: if (tick) nstate = ST_FIN;
            ST_FIN:  nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= '0;
            bits_left <= '0;
            hreg      <= DIV_W'(1);
        end else begin
            if (rst_go || accept) begin
                hreg <= (half_div == '0) ? DIV_W'(1) : half_div;
            end
            if (accept) begin
                sr        <= frame;
                bits_left <= BC_W'(TOTAL - 1);
            end else if (state == ST_HI && tick) begin
                sr <= sr >> 1;
                if (bits_left != '0) bits_left <= bits_left - 1'b1;
            end
        end
    end

    always_comb begin
        sck       = (state == ST_HI);
        ld        = (state == ST_LOAD);
        dev_rst_n = (state != ST_RSTP);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        sdo       = sr[0];
    end

    // R5: data holds while the shift clock stays high
    a_r5_sdo_stable_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo));
    // R7: latch strobe never overlaps a high clock phase
    a_r7_ld_not_sck: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> !sck);
    // R9: latch only inside a busy window
    a_r9_ld_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> busy);
    // R10: done only right after the latch pulse
    a_r10_done_after_ld: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ld) && !ld));
    // R11: device reset keeps clock and latch quiet and marks busy
    a_r11_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst_n |-> (!sck && !ld && busy));
endmodule

// File: tb/sim_serdac_chain_tx.sv
module sim_serdac_chain_tx;
    localparam int ND  = 3;
    localparam int DW  = 8;
    localparam int TOT = ND * 14;

    logic clk = 0;
    logic rst_n = 0;
    logic [DW-1:0] half_div = 1;
    logic msb_first = 0, start = 0, rst_req = 0;
    logic [ND*4-1:0]  cmd_addr = '0;
    logic [ND*10-1:0] cmd_code = '0;
    logic sck, sdo, ld, dev_rst_n, busy, done;

    serdac_chain_tx #(.N_DEV(ND), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .msb_first(msb_first),
        .start(start), .rst_req(rst_req), .cmd_addr(cmd_addr), .cmd_code(cmd_code),
        .sck(sck), .sdo(sdo), .ld(ld), .dev_rst_n(dev_rst_n), .busy(busy), .done(done));

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    int exp_addr[ND];
    int exp_code[ND];
    int h_cur = 1;
    bit mode_cur = 0;
    int rises = 0, ld_pulses = 0, done_pulses = 0;
    int hi_cnt = 0, lo_cnt = 0, ld_cnt = 0, rl_cnt = 0;
    logic prev_sck = 0, prev_sdo = 0, prev_ld = 0, prev_rst = 1;
    logic [TOT-1:0] chain = '0;
    int cyc = 0;

    task automatic chk(bit ok, string tag, int got, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, expv);
        end
    endtask

    // Chain model and timing monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck && prev_sck && sdo !== prev_sdo)
                chk(0, "R5 sdo moved while sck high", sdo, prev_sdo);
            if (sck && !prev_sck) begin
                if (rises > 0) chk(lo_cnt == h_cur, "R6 low phase", lo_cnt, h_cur);
                rises++;
                chain = {chain[TOT-2:0], sdo};
                hi_cnt = 1;
            end else if (sck) hi_cnt++;
            if (!sck && prev_sck) begin
                chk(hi_cnt == h_cur, "R6 high phase", hi_cnt, h_cur);
                lo_cnt = 1;
            end else if (!sck) lo_cnt++;
            if (ld && sck) chk(0, "R7 ld with sck", 1, 0);
            if (ld && !prev_ld) begin
                ld_pulses++;
                ld_cnt = 1;
                chk(lo_cnt - 1 == h_cur, "R7 gap before ld", lo_cnt - 1, h_cur);
                chk(rises == TOT, "R4 rising edges", rises, TOT);
                for (int d = 0; d < ND; d++) begin
                    logic [13:0] w;
                    int a, c;
                    w = chain[d*14 +: 14];
                    a = {w[10], w[11], w[12], w[13]};
                    c = 0;
                    for (int i = 0; i < 10; i++)
                        if (mode_cur) c[i] = w[i];
                        else          c[i] = w[9-i];
                    chk(a == exp_addr[d], "R2 R3 device address", a, exp_addr[d]);
                    chk(c == exp_code[d], mode_cur ? "R8 R3 code msb-first" : "R2 R3 code lsb-first",
                        c, exp_code[d]);
                end
            end else if (ld) ld_cnt++;
            if (!ld && prev_ld) begin
                chk(ld_cnt == h_cur, "R7 ld width", ld_cnt, h_cur);
                chk(done == 1'b1, "R10 done after ld", done, 1);
            end
            if (done) done_pulses++;
            if (!dev_rst_n) begin
                rl_cnt++;
                if (sck || ld) chk(0, "R11 activity during reset", 1, 0);
            end
            if (dev_rst_n && !prev_rst)
                chk(rl_cnt == h_cur, "R11 reset width", rl_cnt, h_cur);
            prev_sck = sck; prev_sdo = sdo; prev_ld = ld; prev_rst = dev_rst_n;
        end
    end

    task automatic clear_mon();
        rises = 0; ld_pulses = 0; done_pulses = 0; rl_cnt = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_xfer(int h, bit m, int seed);
        @(negedge clk);
        half_div = DW'(h);
        msb_first = m;
        h_cur = (h == 0) ? 1 : h;
        mode_cur = m;
        for (int d = 0; d < ND; d++) begin
            exp_addr[d] = (seed + d * 5) % 16;
            exp_code[d] = (seed * 37 + d * 311 + 1) % 1024;
            cmd_addr[d*4 +: 4]   = 4'(exp_addr[d]);
            cmd_code[d*10 +: 10] = 10'(exp_code[d]);
        end
        clear_mon();
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        repeat (4) @(negedge clk);
        // R9: new request and changed commands mid-transfer
        cmd_addr = ~cmd_addr;
        cmd_code = ~cmd_code;
        msb_first = ~m;
        start = 1;
        @(negedge clk);
        start = 0;
        wait_idle();
        chk(ld_pulses == 1, "R9 one latch per start", ld_pulses, 1);
        chk(done_pulses == 1, "R10 single done", done_pulses, 1);
        chk(rises == TOT, "R4 total edges", rises, TOT);
        chk(sck == 0 && ld == 0, "R7 idle lines", {sck, ld}, 0);
    endtask

    task automatic run_reset(int h, bit with_start);
        @(negedge clk);
        half_div = DW'(h);
        h_cur = (h == 0) ? 1 : h;
        clear_mon();
        rst_req = 1;
        start = with_start;
        @(negedge clk);
        rst_req = 0;
        start = 0;
        chk(dev_rst_n == 1'b0 && busy == 1'b1, "R11 reset pulse begins", {dev_rst_n, busy}, 1);
        wait_idle();
        chk(rl_cnt == h_cur, "R11 reset low cycles", rl_cnt, h_cur);
        chk(rises == 0, "R12 no shifting with reset", rises, 0);
        chk(ld_pulses == 0, "R12 no latch with reset", ld_pulses, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "R4 watchdog expired", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sck == 0 && ld == 0 && sdo == 0, "R1 lines low in reset", {sck, ld, sdo}, 0);
        chk(busy == 0 && done == 0 && dev_rst_n == 1, "R1 status in reset",
            {busy, done, dev_rst_n}, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(sck == 0 && ld == 0 && sdo == 0 && busy == 0 && done == 0 && dev_rst_n == 1,
            "R1 after release", {sck, ld, sdo, busy, done, dev_rst_n}, 1);
        for (int h = 0; h < 4; h++) begin
            for (int m = 0; m < 2; m++) begin
                run_xfer(h, m[0], h * 7 + m * 3 + 2);
            end
        end
        run_xfer(2, 0, 15);
        run_xfer(1, 1, 0);
        run_reset(1, 0);
        run_reset(3, 1);
        run_reset(0, 1);
        run_xfer(3, 1, 9);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule